// File: doc/BRIEF.md
# Master-Referenced Current Share Trimmer

This block runs the digital current-balancing loop for one phase of a group of regulators whose outputs are tied together. Every phase sees the same set of group positions and the same shared event bus, which is modelled here as a message port carrying a valid strobe, a 5-bit rail identifier and a current value. Each phase works out on its own whether it holds master duty. Master duty goes to the lowest-numbered position that is still active.

The master sends every fresh local current sample onto the bus and holds its voltage trim at zero. Every other active phase in the same rail keeps the latest current value from the master. Once per update period it moves a signed voltage-trim register by one LSB toward the value that would make its own current match the master's. It makes no move while the error is inside a programmable deadband, and the trim stops at programmable signed limits.

If the master drops out, the next lowest active position takes over and its trim returns to zero. A host may load the trim only while sharing is switched off.

Top module: `share_trim_loop`

## Requirements
- R1: Position p (1..NPOS) is active when bit p-1 of `active_vec` is set. `is_master` rises one cycle after `share_en` is high, the phase's own position bit is set and no lower position bit is set. Otherwise it is low.
- R2: Each `loc_vld` pulse seen while the phase qualifies as master produces, on the next cycle, a one-cycle `tx_vld` with `tx_cur` equal to the sample and `tx_id` equal to `cfg_rail_id`. No `tx_vld` is produced otherwise.
- R3: The error is the reference current minus the local current. On a slave update, the trim rises by one when the error exceeds `deadband` and falls by one when the error is below minus `deadband`.
- R4: While `is_master` is high, `trim_out` is zero, and bus messages do not change it.
- R5: With `share_en` low, `host_wr` loads `host_data` into `trim_out` on the next cycle. With `share_en` high, host writes have no effect.
- R6: When the current master's bit clears, the phase with the next lowest active position becomes master one cycle later, with `trim_out` at zero.
- R7: A bus message is taken as the reference only if `rx_id` equals `cfg_rail_id`. Messages with other identifiers leave the trim unchanged.
- R8: Updates come every UPD_CYC cycles, and the trim moves by at most one LSB per update. An error whose magnitude is at most `deadband` (the boundary included) leaves the trim unchanged.
- R9: Slave stepping never takes `trim_out` above `trim_hi` or below `trim_lo`. The trim saturates at those values.
- R10: If a promotion to master and an update fall in the same cycle, the trim becomes zero and no step is applied.
- R11: A slave holds its trim until it has a reference from the bus and a local sample. A phase whose own position bit is clear holds its trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| share_en | input | 1 | Sharing enable; when low, the trim belongs to the host |
| cfg_rail_id | input | 5 | Rail identifier of this group |
| cfg_pos | input | POS_W | Own group position, 1..NPOS |
| active_vec | input | NPOS | Bit p-1 set means position p is active |
| loc_cur | input | CUR_W | Local output-current sample |
| loc_vld | input | 1 | Strobe for `loc_cur` |
| rx_vld | input | 1 | Bus message strobe |
| rx_id | input | 5 | Rail identifier of the message |
| rx_cur | input | CUR_W | Current carried by the message |
| deadband | input | CUR_W | Error magnitude tolerated without stepping |
| trim_hi | input | TRIM_W | Signed upper trim limit |
| trim_lo | input | TRIM_W | Signed lower trim limit |
| host_wr | input | 1 | Host write strobe for the trim |
| host_data | input | TRIM_W | Signed host trim value |
| tx_vld | output | 1 | Broadcast strobe |
| tx_id | output | 5 | Rail identifier of the broadcast |
| tx_cur | output | CUR_W | Broadcast current |
| is_master | output | 1 | Phase holds master duty |
| trim_out | output | TRIM_W | Signed voltage trim |

## Verification
Two events can fall on the same clock edge: a change of master duty and a periodic trim update. The bench watches `trim_out` for the edge on which it steps, which fixes the phase of the update counter from the ports alone. It then clears the old master's position bit so that the promotion lands exactly on the next update edge. The check passes only if the trim reads zero and `is_master` is high on that cycle; a step applied after the promotion would show a nonzero trim. A second pairing, a host write arriving while sharing is on and the loop is saturated, is judged by the trim staying at its limit.

// File: rtl/share_pkg.sv
package share_pkg;
    localparam int RAIL_W = 5;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;
endpackage

// File: rtl/share_role_elect.sv
module share_role_elect #(
    parameter int NPOS  = 8,
    parameter int POS_W = 4
) (
    input  logic [POS_W-1:0] pos,
    input  logic [NPOS-1:0]  active_vec,
    input  logic             share_en,
    output logic             member,
    output logic             master
);
    // below[i]: some position lower than i+1 is active
    logic [NPOS-1:0] below;
    logic [NPOS-1:0] own_hit;
    logic [NPOS-1:0] own_low;

    assign below[0] = 1'b0;
    generate
        for (genvar i = 1; i < NPOS; i++) begin : g_prefix
            assign below[i] = below[i-1] | active_vec[i-1];
        end
        for (genvar i = 0; i < NPOS; i++) begin : g_match
            assign own_hit[i] = (pos == POS_W'(i + 1)) && active_vec[i];
            assign own_low[i] = own_hit[i] && !below[i];
        end
    endgenerate

    assign member = share_en && (|own_hit);
    assign master = share_en && (|own_low);
endmodule

// File: rtl/share_msg_rx.sv
module share_msg_rx
    import share_pkg::*;
#(
    parameter int CUR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAIL_W-1:0] rail_id,
    input  logic              listen,
    input  logic              rx_vld,
    input  logic [RAIL_W-1:0] rx_id,
    input  logic [CUR_W-1:0]  rx_cur,
    output logic [CUR_W-1:0]  ref_cur,
    output logic              ref_ok
);
    typedef struct packed {
        logic [CUR_W-1:0] cur;
        logic             ok;
    } ref_t;

    ref_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!listen) begin
            r_d.ok = 1'b0;
        end else if (rx_vld && (rx_id == rail_id)) begin
            r_d.cur = rx_cur;
            r_d.ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ref_cur = r_q.cur;
    assign ref_ok  = r_q.ok;
endmodule

// File: rtl/share_trim_core.sv
module share_trim_core
    import share_pkg::*;
#(
    parameter int CUR_W   = 12,
    parameter int TRIM_W  = 10,
    parameter int UPD_CYC = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     share_en,
    input  logic                     member,
    input  logic                     master,
    input  logic [CUR_W-1:0]         ref_cur,
    input  logic                     ref_ok,
    input  logic [CUR_W-1:0]         loc_cur,
    input  logic                     loc_vld,
    input  logic [CUR_W-1:0]         deadband,
    input  logic signed [TRIM_W-1:0] trim_hi,
    input  logic signed [TRIM_W-1:0] trim_lo,
    input  logic                     host_wr,
    input  logic signed [TRIM_W-1:0] host_data,
    output logic signed [TRIM_W-1:0] trim
);
    localparam int CNT_W = (UPD_CYC > 1) ? $clog2(UPD_CYC) : 1;
    localparam int ERR_W = CUR_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CUR_W-1:0]  loc;
        logic              loc_ok;
        logic [TRIM_W-1:0] trim;
    } core_t;

    core_t s_d, s_q;
    logic              tick;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] db_s;
    step_e             dir;
    logic signed [TRIM_W-1:0] cur_trim;

    always_comb begin
        s_d      = s_q;
        cur_trim = $signed(s_q.trim);
        tick     = (s_q.cnt == CNT_W'(UPD_CYC - 1));
        s_d.cnt  = tick ? '0 : s_q.cnt + CNT_W'(1);

        if (loc_vld) begin
            s_d.loc    = loc_cur;
            s_d.loc_ok = 1'b1;
        end

        err  = $signed({2'b00, ref_cur}) - $signed({2'b00, s_q.loc});
        db_s = $signed({2'b00, deadband});
        if (err > db_s)       dir = STEP_UP;
        else if (err < -db_s) dir = STEP_DN;
        else                  dir = STEP_HOLD;

        if (!share_en) begin
            if (host_wr) s_d.trim = host_data;
        end else if (master) begin
            s_d.trim = '0;
        end else if (member && tick && ref_ok && s_q.loc_ok) begin
            unique case (dir)
                STEP_UP: s_d.trim = (cur_trim >= trim_hi) ? trim_hi
                                                          : s_q.trim + TRIM_W'(1);
                STEP_DN: s_d.trim = (cur_trim <= trim_lo) ? trim_lo
                                                          : s_q.trim - TRIM_W'(1);
                default: s_d.trim = s_q.trim;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trim = $signed(s_q.trim);
endmodule

// File: rtl/share_trim_loop.sv
module share_trim_loop
    import share_pkg::*;
#(
    parameter int NPOS    = 8,
    parameter int CUR_W   = 12,
    parameter int TRIM_W  = 10,
    parameter int UPD_CYC = 64,
    localparam int POS_W  = $clog2(NPOS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     share_en,
    input  logic [RAIL_W-1:0]        cfg_rail_id,
    input  logic [POS_W-1:0]         cfg_pos,
    input  logic [NPOS-1:0]          active_vec,
    input  logic [CUR_W-1:0]         loc_cur,
    input  logic                     loc_vld,
    input  logic                     rx_vld,
    input  logic [RAIL_W-1:0]        rx_id,
    input  logic [CUR_W-1:0]         rx_cur,
    input  logic [CUR_W-1:0]         deadband,
    input  logic signed [TRIM_W-1:0] trim_hi,
    input  logic signed [TRIM_W-1:0] trim_lo,
    input  logic                     host_wr,
    input  logic signed [TRIM_W-1:0] host_data,
    output logic                     tx_vld,
    output logic [RAIL_W-1:0]        tx_id,
    output logic [CUR_W-1:0]         tx_cur,
    output logic                     is_master,
    output logic signed [TRIM_W-1:0] trim_out
);
    typedef struct packed {
        logic              tx_vld;
        logic [RAIL_W-1:0] tx_id;
        logic [CUR_W-1:0]  tx_cur;
        logic              master;
    } top_t;

    top_t t_d, t_q;
    logic member_c, master_c;
    logic [CUR_W-1:0] ref_cur;
    logic ref_ok;

    share_role_elect #(.NPOS(NPOS), .POS_W(POS_W)) u_elect (
        .pos        (cfg_pos),
        .active_vec (active_vec),
        .share_en   (share_en),
        .member     (member_c),
        .master     (master_c)
    );

    share_msg_rx #(.CUR_W(CUR_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_id (cfg_rail_id),
        .listen  (member_c && !master_c),
        .rx_vld  (rx_vld),
        .rx_id   (rx_id),
        .rx_cur  (rx_cur),
        .ref_cur (ref_cur),
        .ref_ok  (ref_ok)
    );

    share_trim_core #(.CUR_W(CUR_W), .TRIM_W(TRIM_W), .UPD_CYC(UPD_CYC)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .share_en  (share_en),
        .member    (member_c),
        .master    (master_c),
        .ref_cur   (ref_cur),
        .ref_ok    (ref_ok),
        .loc_cur   (loc_cur),
        .loc_vld   (loc_vld),
        .deadband  (deadband),
        .trim_hi   (trim_hi),
        .trim_lo   (trim_lo),
        .host_wr   (host_wr),
        .host_data (host_data),
        .trim      (trim_out)
    );

    always_comb begin
        t_d        = t_q;
        t_d.master = master_c;
        t_d.tx_vld = master_c && loc_vld;
        if (master_c && loc_vld) begin
            t_d.tx_id  = cfg_rail_id;
            t_d.tx_cur = loc_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tx_vld    = t_q.tx_vld;
    assign tx_id     = t_q.tx_id;
    assign tx_cur    = t_q.tx_cur;
    assign is_master = t_q.master;
endmodule

// File: rtl/share_trim_loop_chk.sv
module share_trim_loop_chk #(
    parameter int TRIM_W = 10,
    parameter int RAIL_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     share_en,
    input logic [RAIL_W-1:0]        cfg_rail_id,
    input logic                     host_wr,
    input logic signed [TRIM_W-1:0] host_data,
    input logic signed [TRIM_W-1:0] trim_hi,
    input logic signed [TRIM_W-1:0] trim_lo,
    input logic                     tx_vld,
    input logic [RAIL_W-1:0]        tx_id,
    input logic                     is_master,
    input logic signed [TRIM_W-1:0] trim_out
);
    AST_MASTER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> $past(share_en)); // R1

    AST_TX_FROM_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> is_master); // R2

    AST_TX_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> (tx_id == $past(cfg_rail_id))); // R2

    AST_MASTER_TRIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> (trim_out == '0)); // R4

    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!share_en && host_wr) |-> (trim_out == $past(host_data))); // R5

    AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (share_en && $past(share_en) && !is_master
         && $past(trim_out) <= trim_hi && $past(trim_out) >= trim_lo)
        |-> ((int'(trim_out) - int'($past(trim_out))) >= -1
          && (int'(trim_out) - int'($past(trim_out))) <= 1)); // R8

    AST_NO_LIMIT_BREACH: assert property (@(posedge clk) disable iff (!rst_n)
        (share_en && $past(share_en) && !is_master
         && $past(trim_out) <= trim_hi && $past(trim_out) >= trim_lo)
        |-> (trim_out <= trim_hi && trim_out >= trim_lo)); // R9
endmodule

bind share_trim_loop share_trim_loop_chk #(.TRIM_W(TRIM_W), .RAIL_W(share_pkg::RAIL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .share_en    (share_en),
    .cfg_rail_id (cfg_rail_id),
    .host_wr     (host_wr),
    .host_data   (host_data),
    .trim_hi     (trim_hi),
    .trim_lo     (trim_lo),
    .tx_vld      (tx_vld),
    .tx_id       (tx_id),
    .is_master   (is_master),
    .trim_out    (trim_out)
);

// File: tb/sim_share_trim_loop.sv
`timescale 1ns/1ps
module sim_share_trim_loop;
    localparam int NPOS  = 8;
    localparam int CUR_W = 12;
    localparam int TW    = 10;
    localparam int UPD   = 4;
    localparam int POS_W = $clog2(NPOS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic share_en = 1'b0;
    logic [4:0] cfg_rail_id = '0;
    logic [POS_W-1:0] cfg_pos = '0;
    logic [NPOS-1:0] active_vec = '0;
    logic [CUR_W-1:0] loc_cur = '0;
    logic loc_vld = 1'b0;
    logic rx_vld = 1'b0;
    logic [4:0] rx_id = '0;
    logic [CUR_W-1:0] rx_cur = '0;
    logic [CUR_W-1:0] deadband = '0;
    logic signed [TW-1:0] trim_hi = '0;
    logic signed [TW-1:0] trim_lo = '0;
    logic host_wr = 1'b0;
    logic signed [TW-1:0] host_data = '0;
    logic tx_vld;
    logic [4:0] tx_id;
    logic [CUR_W-1:0] tx_cur;
    logic is_master;
    logic signed [TW-1:0] trim_out;

    int checks = 0;
    int errors = 0;
    logic [CUR_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    share_trim_loop #(.NPOS(NPOS), .CUR_W(CUR_W), .TRIM_W(TW), .UPD_CYC(UPD)) u0 (
        .clk(clk), .rst_n(rst_n), .share_en(share_en), .cfg_rail_id(cfg_rail_id),
        .cfg_pos(cfg_pos), .active_vec(active_vec), .loc_cur(loc_cur), .loc_vld(loc_vld),
        .rx_vld(rx_vld), .rx_id(rx_id), .rx_cur(rx_cur), .deadband(deadband),
        .trim_hi(trim_hi), .trim_lo(trim_lo), .host_wr(host_wr), .host_data(host_data),
        .tx_vld(tx_vld), .tx_id(tx_id), .tx_cur(tx_cur), .is_master(is_master),
        .trim_out(trim_out)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: a sample; pushes an expected broadcast when master duty is expected
    task automatic send_sample(input int v, input bit expect_tx);
        @(negedge clk);
        loc_cur = CUR_W'(v);
        loc_vld = 1'b1;
        if (expect_tx) exp_q.push_back(CUR_W'(v));
        @(negedge clk);
        loc_vld = 1'b0;
    endtask

    task automatic send_msg(input int id, input int v);
        @(negedge clk);
        rx_id = 5'(id);
        rx_cur = CUR_W'(v);
        rx_vld = 1'b1;
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic host_write(input int v);
        @(negedge clk);
        host_data = TW'(v);
        host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic finish_run();
        check_val("R2 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pops expected broadcasts as they appear
    always @(negedge clk) begin
        if (rst_n && tx_vld) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected broadcast: actual %0d expected none", tx_cur);
            end else begin
                logic [CUR_W-1:0] e;
                e = exp_q.pop_front();
                check_val("R2 broadcast current", int'(tx_cur), int'(e));
                check_val("R2 broadcast rail", int'(tx_id), int'(cfg_rail_id));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        int prev;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        check_val("reset trim", int'(trim_out), 0);
        check_val("reset master", int'(is_master), 0);
        check_val("reset tx", int'(tx_vld), 0);

        cfg_rail_id = 5'd5;
        cfg_pos = POS_W'(1);
        active_vec = 8'b0000_0111;
        deadband = CUR_W'(10);
        trim_hi = TW'(20);
        trim_lo = -TW'(20);
        share_en = 1'b1;
        wait_n(2);
        check_val("R1 position 1 is master", int'(is_master), 1);

        send_sample(300, 1);
        send_sample(4095, 1);
        send_sample(0, 1);
        wait_n(2);

        send_msg(5, 1000);
        wait_n(12);
        check_val("R4 master trim ignores bus", int'(trim_out), 0);

        host_write(33);
        wait_n(2);
        check_val("R5 host write locked (master)", int'(trim_out), 0);

        share_en = 1'b0;
        wait_n(1);
        host_write(7);
        check_val("R5 host load when sharing off", int'(trim_out), 7);
        check_val("R1 no master when sharing off", int'(is_master), 0);

        cfg_pos = POS_W'(3);
        share_en = 1'b1;
        send_sample(900, 0);
        wait_n(20);
        check_val("R11 no step without reference", int'(trim_out), 7);
        check_val("R1 position 3 is slave", int'(is_master), 0);

        send_msg(9, 1000);
        wait_n(20);
        check_val("R7 foreign rail ignored", int'(trim_out), 7);

        send_msg(5, 1000);
        wait_n(2);
        t0 = int'(trim_out);
        wait_n(UPD);
        check_val("R8 one LSB per period up (R3)", int'(trim_out), t0 + 1);

        wait_n(100);
        check_val("R9 saturate at upper limit", int'(trim_out), 20);

        host_write(50);
        wait_n(2);
        check_val("R5 host write locked (slave)", int'(trim_out), 20);

        send_sample(1005, 0);
        wait_n(40);
        check_val("R8 inside deadband holds", int'(trim_out), 20);
        send_sample(1010, 0);
        wait_n(40);
        check_val("R8 deadband boundary holds", int'(trim_out), 20);

        send_sample(1011, 0);
        wait_n(2);
        t0 = int'(trim_out);
        wait_n(UPD);
        check_val("R3 step down past deadband", int'(trim_out), t0 - 1);
        wait_n(200);
        check_val("R9 saturate at lower limit", int'(trim_out), -20);

        active_vec = 8'b0000_0011;
        send_sample(900, 0);
        wait_n(40);
        check_val("R11 dropped phase holds trim", int'(trim_out), -20);

        active_vec = 8'b0000_0111;
        cfg_pos = POS_W'(2);
        wait_n(8);
        active_vec = 8'b0000_0110;
        wait_n(1);
        check_val("R6 next lowest promoted", int'(is_master), 1);
        check_val("R6 promoted trim zero", int'(trim_out), 0);
        send_sample(777, 1);
        wait_n(2);

        // R10: land a promotion on an update edge
        active_vec = 8'b0000_0111;
        wait_n(2);
        check_val("R1 demoted when lower active", int'(is_master), 0);
        send_msg(5, 1000);
        prev = int'(trim_out);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(trim_out) != prev) break;
        end
        check_val("R3 first step up from zero", int'(trim_out), 1);
        wait_n(3);
        active_vec = 8'b0000_0110;
        @(negedge clk);
        check_val("R10 promotion wins over step", int'(trim_out), 0);
        check_val("R10 master on update edge", int'(is_master), 1);

        wait_n(4);
        finish_run();
    end
endmodule